// File: doc/BRIEF.md
# Interrupt Controller with Shadow Flags

This block runs the single maskable interrupt of a small 8-bit accumulator processor and holds two complete copies of the N, Z and C condition flags. The interrupt request is a level and is active high. The block looks at it only when the core signals an instruction boundary (a fetch). If the request is high at that point, the core's enable bit is set and no handler is already running, the block asks the core to discard the fetched word. In its place the core executes the substitute word, a call to the vector at 0008h. The pre-empted instruction is never executed, so its own address is the one that gets pushed, and a return-from-interrupt resumes at that instruction.

While the handler runs, an internal in-service state that software cannot reach does three things. It selects the alternate flag copy, so every flag update from the core lands there and the main program's flags are left alone. It forces the program ROM bank output to zero. It blocks any further interrupt. A RETI strobe ends the service: the main flag copy becomes active again and the stored ROM bank is visible again. A core reset clears the in-service state and the ROM bank register. It does not touch either flag copy.

Top module: `irq_shadow_ctl`

## Requirements
- R1: `take_irq` is high in a cycle exactly when `fetch_stb`, `irq_lvl` and `irq_en` are all high, the block is not in service and `cpu_rst` is low. A request that is high in a cycle without `fetch_stb` is not taken.
- R2: `subst_word` is the call opcode in bits 15:12 followed by the vector address in bits 11:0. With the defaults this is 16'h7008.
- R3: The in-service state becomes set at the clock edge that ends a cycle with `take_irq` high. It clears only at an edge with `reti_stb` high or with `cpu_rst` high. `force_bank0` reports this state one cycle after each of these events. A `reti_stb` outside service has no effect.
- R4: While `force_bank0` is high, `rom_bank` is 0. A `bank_we` write made during service is stored and appears on `rom_bank` once the service has ended.
- R5: `cpu_rst` sets the ROM bank register to 0. Outside service, a write with `bank_we` appears on `rom_bank` from the next cycle.
- R6: `flg_q` shows the main flag copy outside service and the alternate copy in service. A write lands in the copy that is active in the cycle of the write. Each copy keeps its value across entry and RETI. Bit 2 is N, bit 1 is Z and bit 0 is C.
- R7: Each flag bit changes only when its own bit of `flg_we` is high. `flg_wd` supplies the new value, and it is visible on `flg_q` in the next cycle.
- R8: `cpu_rst` leaves both flag copies unchanged. After a reset taken during service, `flg_q` shows the main copy.
- R9: A request held high through the whole handler is not taken in the cycle that carries `reti_stb`, even if that cycle also has `fetch_stb`. It is taken on the first fetch after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cpu_rst | input | 1 | Synchronous core reset, active high |
| irq_lvl | input | 1 | Level interrupt request, active high |
| irq_en | input | 1 | Software interrupt enable bit from the core's RAM bank register |
| fetch_stb | input | 1 | Instruction boundary: a new word is fetched this cycle |
| reti_stb | input | 1 | The core is executing return-from-interrupt |
| bank_we | input | 1 | Write strobe for the ROM bank register |
| bank_wd | input | BANK_W | ROM bank write data |
| flg_we | input | NFLAG | Per-flag write enables from the core |
| flg_wd | input | NFLAG | Flag write data |
| take_irq | output | 1 | Replace the fetched word with `subst_word` |
| subst_word | output | INSN_W | Call-to-vector instruction word |
| force_bank0 | output | 1 | In service: the ROM bank is forced to zero |
| rom_bank | output | BANK_W | Active ROM bank |
| flg_q | output | NFLAG | Active flag copy |

## Verification
`take_irq` and `subst_word` are combinational. They are due in the same cycle as the fetch that causes them. `force_bank0`, `rom_bank` and `flg_q` are due one clock edge after the entry, RETI, reset, bank write or flag write that changes them. The bench drives every input just after a falling edge and compares all outputs against its behavioural model 1 ns later. It updates the model only at the next rising edge, so each comparison sees the values that the requirements set for that cycle and for the edge before it.

// File: rtl/irq_shadow_pkg.sv
package irq_shadow_pkg;
   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;

   typedef enum logic {
      BANK_MAIN = 1'b0,
      BANK_ALT  = 1'b1
   } flag_bank_e;
endpackage

// File: rtl/irq_svc_track.sv
module irq_svc_track
   import irq_shadow_pkg::*;
(
   input  logic       clk,
   input  logic       cpu_rst,
   input  logic       irq_lvl,
   input  logic       irq_en,
   input  logic       fetch_stb,
   input  logic       reti_stb,
   output logic       take_irq,
   output logic       in_svc,
   output flag_bank_e bank_sel
);
   logic svc_q;

   // level is sampled only on an instruction boundary
   assign take_irq = fetch_stb & irq_lvl & irq_en & ~svc_q & ~cpu_rst;

   always_ff @(posedge clk) begin
      if (cpu_rst)       svc_q <= 1'b0;
      else if (take_irq) svc_q <= 1'b1;
      else if (reti_stb) svc_q <= 1'b0;
   end

   assign in_svc   = svc_q;
   assign bank_sel = svc_q ? BANK_ALT : BANK_MAIN;
endmodule

// File: rtl/shadow_flag_file.sv
module shadow_flag_file
   import irq_shadow_pkg::*;
#(
   parameter int NFLAG      = 3,
   parameter bit SWAP_FLAGS = 1'b1
) (
   input  logic             clk,
   input  flag_bank_e       bank_sel,
   input  logic [NFLAG-1:0] flg_we,
   input  logic [NFLAG-1:0] flg_wd,
   output logic [NFLAG-1:0] flg_q
);
   // flag storage has no reset: a core reset must leave both copies intact
   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      if (SWAP_FLAGS) begin : g_pair
         logic main_q, alt_q;
         always_ff @(posedge clk) begin
            if (flg_we[i]) begin
               if (bank_sel == BANK_ALT) alt_q  <= flg_wd[i];
               else                      main_q <= flg_wd[i];
            end
         end
         assign flg_q[i] = (bank_sel == BANK_ALT) ? alt_q : main_q;
      end else begin : g_single
         logic one_q;
         always_ff @(posedge clk) begin
            if (flg_we[i]) one_q <= flg_wd[i];
         end
         assign flg_q[i] = one_q;
      end
   end
endmodule

// File: rtl/rom_bank_gate.sv
module rom_bank_gate #(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              cpu_rst,
   input  logic              force_zero,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wd,
   output logic [BANK_W-1:0] rom_bank
);
   logic [BANK_W-1:0] bank_q;

   always_ff @(posedge clk) begin
      if (cpu_rst)      bank_q <= '0;
      else if (bank_we) bank_q <= bank_wd;
   end

   assign rom_bank = force_zero ? '0 : bank_q;
endmodule

// File: rtl/irq_shadow_ctl.sv
module irq_shadow_ctl
   import irq_shadow_pkg::*;
#(
   parameter int BANK_W     = 4,
   parameter int NFLAG      = 3,
   parameter int INSN_W     = 16,
   parameter int OPC_W      = 4,
   parameter int CALL_OPC   = 7,
   parameter int VEC_ADDR   = 8,
   parameter bit SWAP_FLAGS = 1'b1
) (
   input  logic              clk,
   input  logic              cpu_rst,
   input  logic              irq_lvl,
   input  logic              irq_en,
   input  logic              fetch_stb,
   input  logic              reti_stb,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wd,
   input  logic [NFLAG-1:0]  flg_we,
   input  logic [NFLAG-1:0]  flg_wd,
   output logic              take_irq,
   output logic [INSN_W-1:0] subst_word,
   output logic              force_bank0,
   output logic [BANK_W-1:0] rom_bank,
   output logic [NFLAG-1:0]  flg_q
);
   localparam int ADDR_W = INSN_W - OPC_W;

   if (OPC_W < 1 || ADDR_W < 1) begin : g_bad_split
      $error("opcode field must leave room for an address");
   end
   if (CALL_OPC >= (1 << OPC_W) || CALL_OPC < 0) begin : g_bad_opc
      $error("call opcode does not fit its field");
   end
   if (VEC_ADDR >= (1 << ADDR_W) || VEC_ADDR < 0) begin : g_bad_vec
      $error("vector address does not fit the address field");
   end
   if (NFLAG < 1 || BANK_W < 1) begin : g_bad_width
      $error("flag count and bank width must be positive");
   end

   flag_bank_e bank_sel;
   logic       in_svc;

   assign subst_word  = {OPC_W'(CALL_OPC), ADDR_W'(VEC_ADDR)};
   assign force_bank0 = in_svc;

   irq_svc_track u_svc (
      .clk       (clk),
      .cpu_rst   (cpu_rst),
      .irq_lvl   (irq_lvl),
      .irq_en    (irq_en),
      .fetch_stb (fetch_stb),
      .reti_stb  (reti_stb),
      .take_irq  (take_irq),
      .in_svc    (in_svc),
      .bank_sel  (bank_sel)
   );

   shadow_flag_file #(.NFLAG(NFLAG), .SWAP_FLAGS(SWAP_FLAGS)) u_flags (
      .clk      (clk),
      .bank_sel (bank_sel),
      .flg_we   (flg_we),
      .flg_wd   (flg_wd),
      .flg_q    (flg_q)
   );

   rom_bank_gate #(.BANK_W(BANK_W)) u_bank (
      .clk        (clk),
      .cpu_rst    (cpu_rst),
      .force_zero (in_svc),
      .bank_we    (bank_we),
      .bank_wd    (bank_wd),
      .rom_bank   (rom_bank)
   );
endmodule

// File: rtl/irq_shadow_chk.sv
module irq_shadow_chk #(
   parameter int BANK_W = 4,
   parameter int NFLAG  = 3
) (
   input logic              clk,
   input logic              cpu_rst,
   input logic              irq_lvl,
   input logic              irq_en,
   input logic              fetch_stb,
   input logic              reti_stb,
   input logic              bank_we,
   input logic [BANK_W-1:0] bank_wd,
   input logic [NFLAG-1:0]  flg_we,
   input logic [NFLAG-1:0]  flg_wd,
   input logic              take_irq,
   input logic              force_bank0,
   input logic [BANK_W-1:0] rom_bank,
   input logic [NFLAG-1:0]  flg_q
);
   // R1
   take_needs_req_chk: assert property (@(posedge clk) disable iff (cpu_rst)
      take_irq |-> (fetch_stb && irq_lvl && irq_en));

   // R3
   entry_sets_svc_chk: assert property (@(posedge clk) disable iff (cpu_rst)
      take_irq |=> force_bank0);

   // R3
   svc_only_by_take_chk: assert property (@(posedge clk) disable iff (cpu_rst)
      $rose(force_bank0) |-> $past(take_irq));

   // R3
   reti_ends_svc_chk: assert property (@(posedge clk) disable iff (cpu_rst)
      (force_bank0 && reti_stb) |=> !force_bank0);

   // R4
   bank_zero_in_svc_chk: assert property (@(posedge clk) disable iff (cpu_rst)
      force_bank0 |-> (rom_bank == '0));

   // R5
   bank_write_chk: assert property (@(posedge clk) disable iff (cpu_rst)
      (bank_we && !force_bank0 && !take_irq) |=> (rom_bank == $past(bank_wd)));

   // R9
   no_nest_chk: assert property (@(posedge clk) disable iff (cpu_rst)
      (force_bank0 && reti_stb) |-> !take_irq);

   for (genvar i = 0; i < NFLAG; i++) begin : g_flg
      // R7
      flag_write_chk: assert property (@(posedge clk) disable iff (cpu_rst)
         (flg_we[i] && !take_irq && !(force_bank0 && reti_stb))
            |=> (flg_q[i] == $past(flg_wd[i])));
      // R7
      flag_hold_chk: assert property (@(posedge clk) disable iff (cpu_rst)
         (!flg_we[i] && !take_irq && !(force_bank0 && reti_stb)) |=> $stable(flg_q[i]));
   end
endmodule

bind irq_shadow_ctl irq_shadow_chk #(.BANK_W(BANK_W), .NFLAG(NFLAG)) u_chk (
   .clk         (clk),
   .cpu_rst     (cpu_rst),
   .irq_lvl     (irq_lvl),
   .irq_en      (irq_en),
   .fetch_stb   (fetch_stb),
   .reti_stb    (reti_stb),
   .bank_we     (bank_we),
   .bank_wd     (bank_wd),
   .flg_we      (flg_we),
   .flg_wd      (flg_wd),
   .take_irq    (take_irq),
   .force_bank0 (force_bank0),
   .rom_bank    (rom_bank),
   .flg_q       (flg_q)
);

// File: tb/tb_irq_shadow_ctl.sv
module tb_irq_shadow_ctl;
   logic       clk = 1'b0;
   logic       cpu_rst = 1'b1;
   logic       irq_lvl = 1'b0, irq_en = 1'b0, fetch_stb = 1'b0, reti_stb = 1'b0;
   logic       bank_we = 1'b0;
   logic [3:0] bank_wd = '0;
   logic [2:0] flg_we = '0, flg_wd = '0;
   logic        take_irq, force_bank0;
   logic [15:0] subst_word;
   logic [3:0]  rom_bank;
   logic [2:0]  flg_q;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit       m_svc = 1'b0;
   bit [3:0] m_bank = '0;
   bit [2:0] m_main, m_alt, m_main_ok = '0, m_alt_ok = '0;

   always #4 clk = ~clk;

   irq_shadow_ctl dut (
      .clk(clk), .cpu_rst(cpu_rst), .irq_lvl(irq_lvl), .irq_en(irq_en),
      .fetch_stb(fetch_stb), .reti_stb(reti_stb), .bank_we(bank_we), .bank_wd(bank_wd),
      .flg_we(flg_we), .flg_wd(flg_wd), .take_irq(take_irq), .subst_word(subst_word),
      .force_bank0(force_bank0), .rom_bank(rom_bank), .flg_q(flg_q)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // one cycle: drive after negedge, compare, then advance model at posedge
   task automatic cyc(input string req, input bit rst, input bit irq, input bit en,
                      input bit fet, input bit ret, input bit bwe, input bit [3:0] bwd,
                      input bit [2:0] fwe, input bit [2:0] fwd);
      bit exp_take;
      cpu_rst = rst; irq_lvl = irq; irq_en = en; fetch_stb = fet; reti_stb = ret;
      bank_we = bwe; bank_wd = bwd; flg_we = fwe; flg_wd = fwd;
      #1;
      exp_take = fet && irq && en && !m_svc && !rst;
      check(req, "take_irq", int'(take_irq), int'(exp_take));
      check("R2", "subst_word", int'(subst_word), 'h7008);
      check(req, "force_bank0", int'(force_bank0), int'(m_svc));
      check(req, "rom_bank", int'(rom_bank), m_svc ? 0 : int'(m_bank));
      for (int i = 0; i < 3; i++) begin
         if (m_svc ? m_alt_ok[i] : m_main_ok[i])
            check(req, $sformatf("flg_q[%0d]", i), int'(flg_q[i]),
                  int'(m_svc ? m_alt[i] : m_main[i]));
      end
      @(posedge clk);
      for (int i = 0; i < 3; i++) begin
         if (fwe[i]) begin
            if (m_svc) begin m_alt[i] = fwd[i]; m_alt_ok[i] = 1'b1; end
            else begin m_main[i] = fwd[i]; m_main_ok[i] = 1'b1; end
         end
      end
      if (rst) begin m_svc = 1'b0; m_bank = '0; end
      else begin
         if (bwe) m_bank = bwd;
         if (exp_take) m_svc = 1'b1;
         else if (ret) m_svc = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      @(negedge clk);
      // R5 reset state
      cyc("R5", 1, 0, 0, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      cyc("R5", 1, 0, 0, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      // R6 load main flags N=1 Z=0 C=1
      cyc("R6", 0, 0, 0, 0, 0, 0, 4'h0, 3'b111, 3'b101);
      // R5 bank write outside service
      cyc("R5", 0, 0, 0, 0, 0, 1, 4'h5, 3'b000, 3'b000);
      cyc("R5", 0, 0, 0, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      // R1 request without fetch, then fetch with enable low
      cyc("R1", 0, 1, 1, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      cyc("R1", 0, 1, 0, 1, 0, 0, 4'h0, 3'b000, 3'b000);
      // R3 RETI outside service has no effect
      cyc("R3", 0, 0, 1, 1, 1, 0, 4'h0, 3'b000, 3'b000);
      // R1 entry; R6 flag write in the entry cycle goes to main
      cyc("R1", 0, 1, 1, 1, 0, 0, 4'h0, 3'b001, 3'b000);
      // R4 in service, bank forced; R6 load alternate flags
      cyc("R6", 0, 1, 1, 0, 0, 0, 4'h0, 3'b111, 3'b010);
      // R7 partial write of C only
      cyc("R7", 0, 1, 1, 0, 0, 0, 4'h0, 3'b001, 3'b111);
      // R4 bank write during service stays hidden
      cyc("R4", 0, 1, 1, 0, 0, 1, 4'h9, 3'b000, 3'b000);
      // R9 request held high: fetches during service not taken
      cyc("R9", 0, 1, 1, 1, 0, 0, 4'h0, 3'b000, 3'b000);
      cyc("R9", 0, 1, 1, 1, 1, 0, 4'h0, 3'b000, 3'b000);
      // R9 next fetch after RETI takes it; R4 stored bank visible
      cyc("R9", 0, 1, 1, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      cyc("R9", 0, 1, 1, 1, 0, 0, 4'h0, 3'b000, 3'b000);
      // R6 alternate copy retained
      cyc("R6", 0, 0, 1, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      // R8 reset during service keeps both copies, main visible
      cyc("R8", 1, 1, 1, 1, 0, 0, 4'h0, 3'b000, 3'b000);
      cyc("R8", 0, 0, 1, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      // R7 write only Z of main copy
      cyc("R7", 0, 0, 1, 0, 0, 0, 4'h0, 3'b010, 3'b111);
      cyc("R7", 0, 0, 1, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      // R6 re-enter and confirm alternate copy still held
      cyc("R6", 0, 1, 1, 1, 0, 0, 4'h0, 3'b000, 3'b000);
      cyc("R6", 0, 0, 1, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      cyc("R3", 0, 0, 1, 0, 1, 0, 4'h0, 3'b000, 3'b000);
      cyc("R3", 0, 0, 1, 0, 0, 0, 4'h0, 3'b000, 3'b000);
      finish_run();
   end
endmodule